// File: doc/BRIEF.md
# Synchronous DMA Transfer Mode Register

This block stores which synchronous DMA mode a storage device is running in and applies the rules for choosing one. The host sends a set-transfer-mode request with a mode number. The block compares that number against the fastest mode the device supports. If the number is within range, the block stores it and turns on synchronous DMA. If it is too high, the block refuses it and keeps its present setting. Each request is answered one cycle later with a single-cycle accept or reject pulse.

The block has two reset paths, and they behave differently. A software reset keeps the stored mode. A hardware or power-on reset clears it and puts the device back on the default multiword DMA protocol. While synchronous DMA is enabled, a DMA read or write command is routed to the synchronous protocol. When it is disabled, the command stays on the multiword protocol.

The supported modes are nested. The block publishes a mask with one bit per mode. Every mode up to and including the effective maximum is marked as supported.

Top module: `xfer_mode_sel`

## Requirements
- R1: After the asynchronous power-on reset `rstN` is released, `activeMode` is 0, `syncEn` is 0, and `reqAck` and `reqNak` are both 0.
- R2: The effective cap is min(`maxMode`, TOP_MODE). A request with `reqMode` <= cap is accepted at the clock edge where `reqValid` is high. After that edge, `activeMode` equals the requested number, `syncEn` is 1, and `reqAck` is high for exactly one cycle.
- R3: A request with `reqMode` above the cap is refused. After that edge, `reqNak` is high for one cycle, and `activeMode` and `syncEn` keep their previous values.
- R4: Only one mode is held at a time. Each accepted request overwrites the stored mode, whatever was stored before.
- R5: `softRst` has no effect on `activeMode` or `syncEn`.
- R6: A clock edge with `hardRst` high sets `activeMode` to 0 and `syncEn` to 0.
- R7: A request presented in the same cycle as `hardRst` is ignored. Neither `reqAck` nor `reqNak` pulses, and the hardware reset takes effect.
- R8: Bit i of `supportMask` is 1 exactly when i <= cap. A `maxMode` above TOP_MODE is treated as TOP_MODE.
- R9: `xferSync` is `dmaCmd` AND `syncEn`, without delay. A value of 1 routes the command to the synchronous protocol, and 0 routes it to the multiword protocol.
- R10: `reqAck` and `reqNak` are never high together. A pulse appears only in the cycle after a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| hardRst | input | 1 | Synchronous hardware reset, active high |
| softRst | input | 1 | Software reset indication; leaves the mode state untouched |
| maxMode | input | 2 | Static fastest supported mode |
| reqValid | input | 1 | Set-transfer-mode request strobe |
| reqMode | input | 3 | Requested mode number |
| dmaCmd | input | 1 | A DMA read or write command is active |
| activeMode | output | 2 | Stored synchronous DMA mode |
| syncEn | output | 1 | Synchronous DMA enabled |
| reqAck | output | 1 | Request accepted pulse |
| reqNak | output | 1 | Request refused pulse |
| supportMask | output | 3 | One bit per supported mode |
| xferSync | output | 1 | Route the active DMA command to the synchronous protocol |

## Verification
The assertions check on every cycle the following:
- the accept and reject outcomes of each request, with the value stored after it;
- that `hardRst` clears the state and wins over a request in the same cycle;
- that `softRst` leaves the mode unchanged;
- that the two response pulses never overlap;
- the routing output.

The bench scenarios show the sequences that need history:
- a run of accepted requests replacing one another;
- a software reset arriving after a mode has been chosen;
- the support mask across every `maxMode` value, including the out-of-range value 3;
- long random mixes of requests and resets checked against a reference model.

// File: rtl/xfer_mode_pkg.sv
package xfer_mode_pkg;

  // Strobes from the decision logic to the storage datapath
  typedef struct packed {
    logic load;    // store the requested mode and enable sync DMA
    logic clear;   // hardware reset: drop back to multiword DMA
    logic ackSet;  // answer the request with accept
    logic nakSet;  // answer the request with reject
  } mode_strobe_t;

endpackage

// File: rtl/xfer_mode_ctrl.sv
module xfer_mode_ctrl
  import xfer_mode_pkg::*;
#(
  parameter int TOP_MODE = 2,
  parameter int REQ_W    = 3,
  parameter int MODE_W   = 2
) (
  input  logic              hardRst,
  input  logic [MODE_W-1:0] maxMode,
  input  logic              reqValid,
  input  logic [REQ_W-1:0]  reqMode,
  output logic [MODE_W-1:0] capMode,
  output mode_strobe_t      strb
);

  localparam logic [MODE_W-1:0] TopVal = MODE_W'(TOP_MODE);

  logic             inRange;
  logic             reqLive;
  logic [REQ_W-1:0] capWide;

  // Clamp the static capability to the architectural ceiling
  always_comb begin
    if (maxMode > TopVal) capMode = TopVal;
    else                  capMode = maxMode;
  end

  assign capWide = REQ_W'(capMode);
  assign inRange = (reqMode <= capWide);
  // A hardware reset in the same cycle wins over any request
  assign reqLive = reqValid & ~hardRst;

  always_comb begin
    strb.clear  = hardRst;
    strb.load   = reqLive &  inRange;
    strb.ackSet = reqLive &  inRange;
    strb.nakSet = reqLive & ~inRange;
  end

endmodule

// File: rtl/xfer_mode_dp.sv
module xfer_mode_dp
  import xfer_mode_pkg::*;
#(
  parameter int TOP_MODE = 2,
  parameter int REQ_W    = 3,
  parameter int MODE_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  mode_strobe_t      strb,
  input  logic [REQ_W-1:0]  reqMode,
  input  logic [MODE_W-1:0] capMode,
  input  logic              dmaCmd,
  output logic [MODE_W-1:0] activeMode,
  output logic              syncEn,
  output logic              reqAck,
  output logic              reqNak,
  output logic [TOP_MODE:0] supportMask,
  output logic              xferSync
);

  // Mode storage; the soft reset never reaches this register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeMode <= '0;
      syncEn     <= 1'b0;
    end else if (strb.clear) begin
      activeMode <= '0;
      syncEn     <= 1'b0;
    end else if (strb.load) begin
      activeMode <= reqMode[MODE_W-1:0];
      syncEn     <= 1'b1;
    end
  end

  // One-cycle response pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAck <= 1'b0;
      reqNak <= 1'b0;
    end else begin
      reqAck <= strb.ackSet;
      reqNak <= strb.nakSet;
    end
  end

  // Nested support: every mode at or below the cap is available
  for (genvar i = 0; i <= TOP_MODE; i++) begin : g_sup
    assign supportMask[i] = (MODE_W'(i) <= capMode);
  end

  assign xferSync = dmaCmd & syncEn;

endmodule

// File: rtl/xfer_mode_sel.sv
module xfer_mode_sel
  import xfer_mode_pkg::*;
#(
  parameter int TOP_MODE = 2,
  parameter int REQ_W    = 3,
  localparam int MODE_W  = (TOP_MODE > 1) ? $clog2(TOP_MODE + 1) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hardRst,
  input  logic              softRst,
  input  logic [MODE_W-1:0] maxMode,
  input  logic              reqValid,
  input  logic [REQ_W-1:0]  reqMode,
  input  logic              dmaCmd,
  output logic [MODE_W-1:0] activeMode,
  output logic              syncEn,
  output logic              reqAck,
  output logic              reqNak,
  output logic [TOP_MODE:0] supportMask,
  output logic              xferSync
);

  mode_strobe_t      strb;
  logic [MODE_W-1:0] capMode;
  logic              softUnused;

  // The software reset is accepted but deliberately leaves mode state alone
  assign softUnused = softRst;

  xfer_mode_ctrl #(.TOP_MODE(TOP_MODE), .REQ_W(REQ_W), .MODE_W(MODE_W)) u_ctrl (
    .hardRst (hardRst),
    .maxMode (maxMode),
    .reqValid(reqValid),
    .reqMode (reqMode),
    .capMode (capMode),
    .strb    (strb)
  );

  xfer_mode_dp #(.TOP_MODE(TOP_MODE), .REQ_W(REQ_W), .MODE_W(MODE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqMode    (reqMode),
    .capMode    (capMode),
    .dmaCmd     (dmaCmd),
    .activeMode (activeMode),
    .syncEn     (syncEn),
    .reqAck     (reqAck),
    .reqNak     (reqNak),
    .supportMask(supportMask),
    .xferSync   (xferSync)
  );

endmodule

// File: rtl/xfer_mode_chk.sv
module xfer_mode_chk #(
  parameter int TOP_MODE = 2,
  parameter int REQ_W    = 3,
  parameter int MODE_W   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              hardRst,
  input logic              softRst,
  input logic [MODE_W-1:0] maxMode,
  input logic              reqValid,
  input logic [REQ_W-1:0]  reqMode,
  input logic              dmaCmd,
  input logic [MODE_W-1:0] activeMode,
  input logic              syncEn,
  input logic              reqAck,
  input logic              reqNak,
  input logic              xferSync
);

  logic [REQ_W-1:0] limit;
  assign limit = (int'(maxMode) > TOP_MODE) ? REQ_W'(TOP_MODE) : REQ_W'(maxMode);

  // R2 / R4: in-range request is stored and acknowledged
  a_r2_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !hardRst && reqMode <= limit) |=>
      (reqAck && syncEn && REQ_W'(activeMode) == $past(reqMode)));

  // R3: out-of-range request is refused without touching state
  a_r3_reject: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !hardRst && reqMode > limit) |=>
      (reqNak && $stable(activeMode) && $stable(syncEn)));

  // R5: soft reset alone changes nothing
  a_r5_soft_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (softRst && !reqValid && !hardRst) |=> ($stable(activeMode) && $stable(syncEn)));

  // R6: hardware reset clears the mode
  a_r6_hard_clears: assert property (@(posedge clk) disable iff (!rstN)
    hardRst |=> (!syncEn && activeMode == '0));

  // R7: request during hardware reset gets no answer
  a_r7_hard_wins: assert property (@(posedge clk) disable iff (!rstN)
    hardRst |=> (!reqAck && !reqNak));

  // R10: pulses exclusive and only after a request
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(reqAck && reqNak));
  a_r10_cause: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!reqAck && !reqNak));

  // R9: routing follows the enable flag
  always_comb begin
    if (rstN) a_r9_route: assert (xferSync == (dmaCmd && syncEn));
  end

endmodule

bind xfer_mode_sel xfer_mode_chk #(.TOP_MODE(TOP_MODE), .REQ_W(REQ_W), .MODE_W(MODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .hardRst(hardRst), .softRst(softRst), .maxMode(maxMode),
  .reqValid(reqValid), .reqMode(reqMode), .dmaCmd(dmaCmd), .activeMode(activeMode),
  .syncEn(syncEn), .reqAck(reqAck), .reqNak(reqNak), .xferSync(xferSync)
);

// File: tb/sim_xfer_mode_sel.sv
module sim_xfer_mode_sel;

  logic       clk = 1'b0;
  logic       rstN, hardRst, softRst, reqValid, dmaCmd;
  logic [1:0] maxMode;
  logic [2:0] reqMode;
  logic [1:0] activeMode;
  logic       syncEn, reqAck, reqNak, xferSync;
  logic [2:0] supportMask;

  int checks = 0;
  int errors = 0;

  // reference model
  int refMode = 0;
  bit refEn = 0, refAck = 0, refNak = 0;

  always #4 clk = ~clk;  // 125 MHz

  xfer_mode_sel u0 (
    .clk(clk), .rstN(rstN), .hardRst(hardRst), .softRst(softRst), .maxMode(maxMode),
    .reqValid(reqValid), .reqMode(reqMode), .dmaCmd(dmaCmd), .activeMode(activeMode),
    .syncEn(syncEn), .reqAck(reqAck), .reqNak(reqNak), .supportMask(supportMask),
    .xferSync(xferSync)
  );

  function automatic int capOf(int mx);
    return (mx > 2) ? 2 : mx;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    chk(activeMode == refMode, {tag, " mode"}, activeMode, refMode);
    chk(syncEn == refEn, {tag, " en"}, syncEn, refEn);
    chk(reqAck == refAck, {tag, " ack"}, reqAck, refAck);
    chk(reqNak == refNak, {tag, " nak"}, reqNak, refNak);
    chk(xferSync == (dmaCmd & refEn), "R9 route", xferSync, dmaCmd & refEn);
    chk(!(reqAck && reqNak), "R10 exclusive", {reqAck, reqNak}, 0);
  endtask

  // drive one cycle, update model at the edge, compare after it
  task automatic step(bit hr, bit sr, bit rv, int rm, bit dc, string tag);
    @(negedge clk);
    hardRst = hr; softRst = sr; reqValid = rv; reqMode = 3'(rm); dmaCmd = dc;
    @(posedge clk);
    if (hr) begin
      refMode = 0; refEn = 0; refAck = 0; refNak = 0;
    end else if (rv) begin
      refAck = (rm <= capOf(maxMode));
      refNak = !refAck;
      if (refAck) begin refMode = rm; refEn = 1; end
    end else begin
      refAck = 0; refNak = 0;
    end
    #1;
    checkAll(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 0; hardRst = 0; softRst = 0; reqValid = 0; reqMode = 0; dmaCmd = 0; maxMode = 2;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1;
    checkAll("R1 reset");

    step(0, 0, 1, 1, 1, "R2 accept 1");
    step(0, 0, 0, 0, 1, "R10 pulse ends");
    step(0, 0, 1, 2, 0, "R4 replace 2");
    step(0, 0, 1, 3, 1, "R3 reject 3");
    step(0, 0, 1, 7, 1, "R3 reject 7");
    step(0, 0, 1, 0, 1, "R4 replace 0");
    step(0, 0, 1, 2, 1, "R2 accept 2");
    step(0, 1, 0, 0, 1, "R5 soft");
    step(0, 1, 0, 0, 0, "R5 soft hold");
    step(1, 0, 1, 1, 1, "R7 hard+req");
    chk(syncEn == 0, "R6 cleared", syncEn, 0);
    step(1, 0, 0, 0, 0, "R6 hard");

    maxMode = 0;
    step(0, 0, 1, 1, 1, "R3 cap0 reject");
    step(0, 0, 1, 0, 1, "R2 cap0 accept");

    for (int m = 0; m < 4; m++) begin
      @(negedge clk); maxMode = 2'(m); #1;
      for (int i = 0; i < 3; i++)
        chk(supportMask[i] == (i <= capOf(m)), "R8 mask", supportMask[i], (i <= capOf(m)));
    end
    maxMode = 3;
    step(0, 0, 1, 2, 1, "R8 clamp accept");
    step(0, 0, 1, 3, 1, "R8 clamp reject");

    void'($urandom(32'd20251));
    for (int p = 0; p < 4; p++) begin
      maxMode = 2'(p);
      for (int k = 0; k < 300; k++)
        step(($urandom % 20) == 0, ($urandom % 6) == 0, ($urandom % 2) == 1,
             int'($urandom % 8), ($urandom % 2) == 1, "R2R3R4R5R6R7 rand");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule